// File: doc/BRIEF.md
# Break-and-Code Flow Command Sender

This block sits between a payload source and a UART serializer and sends flow-control commands to the far end of the link in a form that cannot be confused with data. A command is a line BREAK followed by one code byte: 13h asks the far end to pause and 11h asks it to resume. The BREAK is made by holding the serializer's output low and loading a zero byte at the same moment. The zero byte sets the length of the BREAK to exactly one character time, and the low level is released only after the serializer reports that it is empty.

Payload bytes pass through a valid/ready handshake into the serializer, one byte at a time. A local pause input stops new payload bytes from starting but never cuts off a byte that is already shifting. Command requests win over payload. A request that arrives while a payload byte is in flight is held until that byte has finished. Command sequences still run while the local pause is active. After the BREAK is released, the line stays idle-high for at least one bit time before the code byte starts.

Top module: `flow_cmd_sender`

## Requirements
- R1: After reset, with `serEmpty` high, `localPause` low and no request, the outputs are `serForceLow`=0, `cmdBusy`=0, `serLoad`=0 and `plReady`=1.
- R2: A payload byte is passed on when `plValid` and `plReady` are both high: `serLoad` pulses in that cycle with `serData` equal to `plData` and `serForceLow` low.
- R3: While `localPause` is high, `plReady` stays low and no payload byte is loaded. The byte held at `plValid` is loaded once `localPause` falls.
- R4: A command loads byte 00h with `serForceLow` high, and after that loads the code byte with `serForceLow` low. The command produces no other loads.
- R5: With `cmdPause`=1 at request time the code byte is 13h (pause). With `cmdPause`=0 it is 11h (resume).
- R6: `serForceLow` falls only in the cycle after `serEmpty` has been seen high, which follows the load of the zero byte.
- R7: At least `BIT_CYCLES` clock cycles pass between the fall of `serForceLow` and the load of the code byte.
- R8: `cmdBusy` rises in the cycle after an accepted `cmdReq` and stays high until the code byte has left the serializer. A `cmdReq` made while `cmdBusy` is high has no effect.
- R9: A command accepted while a byte is shifting (`serEmpty` low) raises `serForceLow` only after `serEmpty` has returned high.
- R10: Commands have priority over payload: `plReady` is low while `cmdReq` or `cmdBusy` is high.
- R11: A command runs to completion, with the same loads as in R4, while `localPause` is high.
- R12: `serLoad` is asserted only when `serEmpty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| plValid | input | 1 | Payload byte available |
| plData | input | DATA_W | Payload byte |
| plReady | output | 1 | Payload byte accepted this cycle when valid |
| cmdReq | input | 1 | Request to send a flow command |
| cmdPause | input | 1 | 1 = pause code 13h, 0 = resume code 11h |
| cmdBusy | output | 1 | Command accepted and not yet finished |
| localPause | input | 1 | Stops new payload bytes from starting |
| serData | output | DATA_W | Byte handed to the serializer |
| serLoad | output | 1 | Load strobe to the serializer |
| serForceLow | output | 1 | Forces the serial line low (BREAK) |
| serEmpty | input | 1 | Serializer idle. It must go low in the cycle after `serLoad` and return high when the character has shifted out |

## Verification
The bench builds the block with `BIT_CYCLES`=4. Its serializer model takes ten bit times, 40 cycles, per character. At this size a whole BREAK, the idle gap and the code byte fit into about a hundred cycles, so many command sequences can run back to back. The short gap also makes the R7 boundary visible: a gap that is one cycle short fails the check. With the default value of 16 the same behaviour would only stretch out in time.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam logic [7:0] PAUSE_CODE  = 8'h13;
  localparam logic [7:0] RESUME_CODE = 8'h11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK_START,
    ST_BRK_WAIT,
    ST_BRK_RELEASE,
    ST_CODE_SEND,
    ST_CODE_WAIT
  } fcsState_t;

  typedef struct packed {
    logic loadPayload;
    logic loadNull;
    logic loadCode;
    logic gapStart;
    logic latchCmd;
    logic clearBusy;
  } fcsStrobe_t;

endpackage

// File: rtl/fcs_datapath.sv
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BIT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fcsStrobe_t        strobe,
  input  logic [DATA_W-1:0] plData,
  input  logic              cmdPause,
  output logic [DATA_W-1:0] serData,
  output logic              serLoad,
  output logic              cmdBusy,
  output logic              gapDone
);

  localparam int GAP_W = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [GAP_W-1:0] GAP_INIT = GAP_W'(BIT_CYCLES - 1);

  logic [DATA_W-1:0] codeReg;
  logic              busyReg;
  logic [GAP_W-1:0]  gapCnt;

  // Command code captured at acceptance so later cmdPause changes cannot alter it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeReg <= '0;
      busyReg <= 1'b0;
    end else begin
      if (strobe.latchCmd) begin
        codeReg <= cmdPause ? DATA_W'(PAUSE_CODE) : DATA_W'(RESUME_CODE);
        busyReg <= 1'b1;
      end else if (strobe.clearBusy) begin
        busyReg <= 1'b0;
      end
    end
  end

  // Idle-gap timer: loaded on release entry, counts down to zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (strobe.gapStart) begin
      gapCnt <= GAP_INIT;
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  assign gapDone = (gapCnt == '0);
  assign cmdBusy = busyReg;
  assign serLoad = strobe.loadPayload | strobe.loadNull | strobe.loadCode;

  always_comb begin
    serData = '0;
    if (strobe.loadCode)         serData = codeReg;
    else if (strobe.loadPayload) serData = plData;
  end

endmodule

// File: rtl/fcs_control.sv
module fcs_control
  import fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdReq,
  input  logic       cmdBusy,
  input  logic       localPause,
  input  logic       plValid,
  input  logic       serEmpty,
  input  logic       gapDone,
  output fcsStrobe_t strobe,
  output logic       plReady,
  output logic       serForceLow
);

  fcsState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    plReady   = 1'b0;

    strobe.latchCmd = cmdReq && !cmdBusy;

    case (state)
      ST_IDLE: begin
        if (cmdBusy) begin
          if (serEmpty) stateNext = ST_BRK_START;
        end else begin
          plReady = serEmpty && !localPause && !cmdReq;
          strobe.loadPayload = plValid && plReady;
        end
      end
      ST_BRK_START: begin
        strobe.loadNull = 1'b1;
        stateNext       = ST_BRK_WAIT;
      end
      ST_BRK_WAIT: begin
        if (serEmpty) begin
          strobe.gapStart = 1'b1;
          stateNext       = ST_BRK_RELEASE;
        end
      end
      ST_BRK_RELEASE: begin
        if (gapDone) stateNext = ST_CODE_SEND;
      end
      ST_CODE_SEND: begin
        strobe.loadCode = 1'b1;
        stateNext       = ST_CODE_WAIT;
      end
      ST_CODE_WAIT: begin
        if (serEmpty) begin
          strobe.clearBusy = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign serForceLow = (state == ST_BRK_START) || (state == ST_BRK_WAIT);

endmodule

// File: rtl/flow_cmd_sender.sv
module flow_cmd_sender #(
  parameter int DATA_W     = 8,
  parameter int BIT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              plValid,
  input  logic [DATA_W-1:0] plData,
  output logic              plReady,
  input  logic              cmdReq,
  input  logic              cmdPause,
  output logic              cmdBusy,
  input  logic              localPause,
  output logic [DATA_W-1:0] serData,
  output logic              serLoad,
  output logic              serForceLow,
  input  logic              serEmpty
);

  fcs_pkg::fcsStrobe_t strobe;
  logic gapDone;

  fcs_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .cmdReq     (cmdReq),
    .cmdBusy    (cmdBusy),
    .localPause (localPause),
    .plValid    (plValid),
    .serEmpty   (serEmpty),
    .gapDone    (gapDone),
    .strobe     (strobe),
    .plReady    (plReady),
    .serForceLow(serForceLow)
  );

  fcs_datapath #(
    .DATA_W    (DATA_W),
    .BIT_CYCLES(BIT_CYCLES)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .plData  (plData),
    .cmdPause(cmdPause),
    .serData (serData),
    .serLoad (serLoad),
    .cmdBusy (cmdBusy),
    .gapDone (gapDone)
  );

endmodule

// File: rtl/flow_cmd_sender_checker.sv
module flow_cmd_sender_checker #(
  parameter int DATA_W     = 8,
  parameter int BIT_CYCLES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              plReady,
  input logic              cmdReq,
  input logic              cmdBusy,
  input logic              localPause,
  input logic [DATA_W-1:0] serData,
  input logic              serLoad,
  input logic              serForceLow,
  input logic              serEmpty
);

  logic [15:0] lowGone;

  always_ff @(posedge clk) begin
    if (!rstN || serForceLow) lowGone <= '0;
    else if (lowGone != 16'hFFFF) lowGone <= lowGone + 1'b1;
  end

  a_r12_load_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    serLoad |-> serEmpty);

  a_r3_pause_blocks: assert property (@(posedge clk) disable iff (!rstN)
    localPause |-> !plReady);

  a_r10_cmd_priority: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq || cmdBusy) |-> !plReady);

  a_r4_break_loads_null: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serForceLow) |-> (serLoad && serData == '0));

  a_r6_release_after_empty: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serForceLow) |-> $past(serEmpty));

  a_r8_busy_from_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdBusy) |-> $past(cmdReq));

  a_r7_idle_gap: assert property (@(posedge clk) disable iff (!rstN)
    (serLoad && cmdBusy && !serForceLow) |-> (lowGone >= 16'(BIT_CYCLES)));

endmodule

bind flow_cmd_sender flow_cmd_sender_checker #(
  .DATA_W    (DATA_W),
  .BIT_CYCLES(BIT_CYCLES)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .plReady    (plReady),
  .cmdReq     (cmdReq),
  .cmdBusy    (cmdBusy),
  .localPause (localPause),
  .serData    (serData),
  .serLoad    (serLoad),
  .serForceLow(serForceLow),
  .serEmpty   (serEmpty)
);

// File: tb/flow_cmd_sender_bench.sv
module flow_cmd_sender_bench;

  localparam int BIT  = 4;
  localparam int CHAR = 10 * BIT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic plValid = 1'b0;
  logic [7:0] plData = '0;
  logic plReady;
  logic cmdReq = 1'b0;
  logic cmdPause = 1'b0;
  logic cmdBusy;
  logic localPause = 1'b0;
  logic [7:0] serData;
  logic serLoad;
  logic serForceLow;
  logic serEmpty;

  always #2 clk = ~clk;

  flow_cmd_sender #(.DATA_W(8), .BIT_CYCLES(BIT)) u_flow_cmd_sender (
    .clk(clk), .rstN(rstN), .plValid(plValid), .plData(plData), .plReady(plReady),
    .cmdReq(cmdReq), .cmdPause(cmdPause), .cmdBusy(cmdBusy), .localPause(localPause),
    .serData(serData), .serLoad(serLoad), .serForceLow(serForceLow), .serEmpty(serEmpty)
  );

  // Serializer model: busy for CHAR cycles after each load
  int serCnt = 0;
  assign serEmpty = (serCnt == 0);

  logic [7:0] logData [256];
  logic       logFl   [256];
  int logN = 0;
  int cycle = 0;
  int fallCycle = 0;
  int minGap = 1000;
  int badRelease = 0;
  int badRise = 0;
  logic prevFl = 1'b0;

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (!rstN) begin
      serCnt <= 0;
    end else begin
      if (serLoad) begin
        serCnt <= CHAR;
        if (logN < 256) begin
          logData[logN] <= serData;
          logFl[logN]   <= serForceLow;
        end
        logN <= logN + 1;
        if (!serForceLow && cmdBusy && (cycle - fallCycle) < minGap)
          minGap <= cycle - fallCycle;
      end else if (serCnt != 0) begin
        serCnt <= serCnt - 1;
      end
      if (prevFl && !serForceLow) begin
        fallCycle <= cycle;
        if (serCnt != 0) badRelease <= badRelease + 1;
      end
      if (!prevFl && serForceLow && serCnt != 0) badRise <= badRise + 1;
      prevFl <= serForceLow;
    end
  end

  int nChecks = 0;
  int nFails = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendPayload(input logic [7:0] d);
    @(negedge clk);
    plValid = 1'b1;
    plData  = d;
    while (!plReady) @(negedge clk);
    @(negedge clk);
    plValid = 1'b0;
  endtask

  task automatic issueCmd(input logic p);
    @(negedge clk);
    cmdReq   = 1'b1;
    cmdPause = p;
    @(negedge clk);
    cmdReq = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (cmdBusy || !serEmpty) @(negedge clk);
  endtask

  // {kind[1:0] (0 payload, 1 pause cmd, 2 resume cmd), data, exp0, exp1, nLoads[1:0]}
  localparam logic [27:0] VEC [6] = '{
    {2'd0, 8'hA5, 8'hA5, 8'h00, 2'd1},
    {2'd1, 8'h00, 8'h00, 8'h13, 2'd2},
    {2'd0, 8'h13, 8'h13, 8'h00, 2'd1},
    {2'd2, 8'h00, 8'h00, 8'h11, 2'd2},
    {2'd0, 8'h00, 8'h00, 8'h00, 2'd1},
    {2'd1, 8'h00, 8'h00, 8'h13, 2'd2}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(serForceLow == 1'b0, "R1 forceLow", serForceLow, 0);
    check(cmdBusy == 1'b0, "R1 busy", cmdBusy, 0);
    check(serLoad == 1'b0, "R1 load", serLoad, 0);
    check(plReady == 1'b1, "R1 ready", plReady, 1);

    // Vector loop: R2 payload, R4 break/code, R5 codes
    for (int v = 0; v < 6; v++) begin
      logic [1:0] kind;
      logic [7:0] d, e0, e1;
      logic [1:0] n;
      {kind, d, e0, e1, n} = VEC[v];
      base = logN;
      if (kind == 2'd0) sendPayload(d);
      else issueCmd(kind == 2'd1);
      waitIdle();
      check(logN - base == int'(n), "R4 load count", logN - base, n);
      check(logData[base] == e0, "R2 first byte", logData[base], e0);
      check(logFl[base] == (kind != 2'd0), "R4 forceLow at first load", logFl[base], kind != 2'd0);
      if (n == 2'd2) begin
        check(logData[base+1] == e1, "R5 code byte", logData[base+1], e1);
        check(logFl[base+1] == 1'b0, "R4 code forceLow", logFl[base+1], 0);
      end
    end

    // R3 local pause blocks payload
    base = logN;
    @(negedge clk);
    localPause = 1'b1;
    plValid = 1'b1;
    plData = 8'h5A;
    repeat (50) @(negedge clk);
    check(logN == base, "R3 no load during pause", logN - base, 0);
    check(plReady == 1'b0, "R3 ready low", plReady, 0);
    // R11 command under pause
    issueCmd(1'b0);
    waitIdle();
    check(logN - base == 2, "R11 loads under pause", logN - base, 2);
    check(logData[base+1] == 8'h11, "R11 code under pause", logData[base+1], 8'h11);
    localPause = 1'b0;
    while (!plReady) @(negedge clk);
    @(negedge clk);
    plValid = 1'b0;
    waitIdle();
    check(logData[base+2] == 8'h5A, "R3 resume after pause", logData[base+2], 8'h5A);

    // R9 command during payload byte
    base = logN;
    sendPayload(8'h3C);
    issueCmd(1'b1);
    waitIdle();
    check(logN - base == 3, "R9 load count", logN - base, 3);
    check(logData[base] == 8'h3C && logFl[base+1] == 1'b1, "R9 payload first", logData[base], 8'h3C);
    check(badRise == 0, "R9 forceLow rise while shifting", badRise, 0);

    // R8 busy and ignored request
    base = logN;
    issueCmd(1'b1);
    check(cmdBusy == 1'b1, "R8 busy after accept", cmdBusy, 1);
    repeat (5) @(negedge clk);
    issueCmd(1'b0);
    waitIdle();
    check(logN - base == 2, "R8 ignored request loads", logN - base, 2);
    check(logData[base+1] == 8'h13, "R8 first code kept", logData[base+1], 8'h13);
    check(cmdBusy == 1'b0, "R8 busy cleared", cmdBusy, 0);

    // R10 priority: request and payload together
    base = logN;
    @(negedge clk);
    plValid = 1'b1;
    plData = 8'hC3;
    cmdReq = 1'b1;
    cmdPause = 1'b0;
    @(negedge clk);
    cmdReq = 1'b0;
    while (!plReady) @(negedge clk);
    @(negedge clk);
    plValid = 1'b0;
    waitIdle();
    check(logFl[base] == 1'b1 && logData[base] == 8'h00, "R10 break first", logData[base], 0);
    check(logData[base+2] == 8'hC3, "R10 payload after command", logData[base+2], 8'hC3);

    // R6 / R7 / R12 monitors
    check(badRelease == 0, "R6 release before empty", badRelease, 0);
    check(minGap >= BIT, "R7 idle gap", minGap, BIT);
    check(serEmpty == 1'b1 && serLoad == 1'b0, "R12 idle end", serLoad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule